// File: doc/BRIEF.md
# Sliding-Window Weighted Mean Updater

This block keeps one high-resolution pixel's weighted mean current as a window of low-resolution frames slides forward. For each output coordinate it is given four things: the intensity and cumulative weight stored for the previous frame, the pixel and weight of the newest frame that lands on this coordinate, and the pixel and weight of the frame that is leaving the window. It adds the newest term to the running sum and removes the departing one. The updated sum is then divided by the new cumulative weight. The result is a fresh intensity and weight, and the block accepts and returns one pixel on every clock.

There is no divider. The new weight is normalised to an 8-bit mantissa plus a right-shift count. The mantissa indexes a 256-entry reciprocal table, and the shift is applied again after the multiply. The pipeline has six register stages, and each stage holds at most one adder or one multiplier per data path. The valid flag and the pixel coordinate travel in a delay line of matching length. The result leaves on two identical ports: one feeds the next processing stage, and the other writes the value back as the stored state for the following frame.

Top module: `wmean_slide_upd`

## Requirements
- R1: The output weight is prev_wt + new_wt − old_wt, forced to 0 when that value is zero or negative and limited to 2^WT_W − 1 (4095 by default) when it is larger.
- R2: The weighted sum is N = prev_pix·prev_wt + new_pix·new_wt − old_pix·old_wt. A negative N is treated as 0.
- R3: For an output weight W > 0, let s be the smallest shift for which m = W >> s is below 256, and let T(m) = floor((65536 + floor(m/2)) / m). The output intensity is then (N·T(m) + 2^(15+s)) >> (16+s).
- R4: An intensity computed by R3 that exceeds 255 is output as 255.
- R5: When the output weight is 0, the output intensity is 0, which marks the pixel as missing.
- R6: out_valid equals in_valid delayed by exactly 6 clock edges. Reset clears it.
- R7: Inputs presented on consecutive clocks produce results on consecutive clocks, with no gaps, and a gap in the input shows up as a gap in the output.
- R8: out_coord carries the in_coord that was sampled together with the inputs that produced the result.
- R9: wb_en, wb_coord, wb_pix and wb_wt always equal out_valid, out_coord, out_pix and out_wt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input set present this cycle |
| in_coord | input | COORD_W | High-resolution coordinate tag |
| prev_pix | input | PIX_W | Stored intensity from the previous frame |
| prev_wt | input | WT_W | Stored cumulative weight from the previous frame |
| new_pix | input | PIX_W | Pixel of the newest frame |
| new_wt | input | WT_W | Weight of the newest frame's pixel |
| old_pix | input | PIX_W | Pixel of the frame leaving the window |
| old_wt | input | WT_W | Weight of the frame leaving the window |
| out_valid | output | 1 | Result present |
| out_coord | output | COORD_W | Coordinate of the result |
| out_pix | output | PIX_W | Updated intensity |
| out_wt | output | WT_W | Updated cumulative weight |
| wb_en | output | 1 | Write-back strobe |
| wb_coord | output | COORD_W | Write-back coordinate |
| wb_pix | output | PIX_W | Write-back intensity |
| wb_wt | output | WT_W | Write-back weight |

## Verification
The hardest cases to reach come from inconsistent input triples. With consistent data, the departing term can never outweigh what is stored, so a zero or negative new weight together with a nonzero numerator never occurs, and neither does a negative numerator under a positive weight. The directed tests therefore build these triples by hand. They also place weights right at the normalisation boundaries (255, 256, 4095 and beyond) so that every shift count is exercised. A pseudo-random back-to-back stream and a stream with bubbles then check that result order, coordinate alignment and gaps survive the six-stage pipeline.

// File: rtl/wmean_pkg.sv
package wmean_pkg;

    // Register stages from input sample to result
    localparam int unsigned WM_LAT = 6;

    // Fraction bits of each reciprocal table entry
    localparam int unsigned WM_RECIP_FRAC = 16;

    // Rounded reciprocal of m in WM_RECIP_FRAC fraction bits; entry 0 is unused
    function automatic int unsigned recip_entry(int unsigned m, int unsigned frac);
        if (m == 0) return 0;
        return ((32'd1 << frac) + m / 2) / m;
    endfunction

endpackage

// File: rtl/wmean_mac.sv
// Stages 1..3: products, partial sums, numerator and clipped weight
module wmean_mac #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned WT_W  = 12,
    localparam int unsigned PROD_W = PIX_W + WT_W,
    localparam int unsigned NUM_W  = PROD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  prev_pix,
    input  logic [WT_W-1:0]   prev_wt,
    input  logic [PIX_W-1:0]  new_pix,
    input  logic [WT_W-1:0]   new_wt,
    input  logic [PIX_W-1:0]  old_pix,
    input  logic [WT_W-1:0]   old_wt,
    output logic [NUM_W-1:0]  num_o,
    output logic [WT_W-1:0]   wt_o
);

    // stage 1
    logic [PROD_W-1:0]        prod_prev_q, prod_new_q, prod_old_q;
    logic [WT_W:0]            wsum_a_q;
    logic [WT_W-1:0]          old_wt_q;
    // stage 2
    logic [PROD_W:0]          sum_pn_q;
    logic [PROD_W-1:0]        prod_old_d2;
    logic signed [WT_W+1:0]   wsum_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_prev_q <= '0;
            prod_new_q  <= '0;
            prod_old_q  <= '0;
            wsum_a_q    <= '0;
            old_wt_q    <= '0;
        end else begin
            prod_prev_q <= PROD_W'(prev_pix) * PROD_W'(prev_wt);
            prod_new_q  <= PROD_W'(new_pix) * PROD_W'(new_wt);
            prod_old_q  <= PROD_W'(old_pix) * PROD_W'(old_wt);
            wsum_a_q    <= (WT_W+1)'(prev_wt) + (WT_W+1)'(new_wt);
            old_wt_q    <= old_wt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_pn_q    <= '0;
            prod_old_d2 <= '0;
            wsum_b_q    <= '0;
        end else begin
            sum_pn_q    <= (PROD_W+1)'(prod_prev_q) + (PROD_W+1)'(prod_new_q);
            prod_old_d2 <= prod_old_q;
            wsum_b_q    <= $signed({1'b0, wsum_a_q}) - $signed({2'b00, old_wt_q});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_o <= '0;
            wt_o  <= '0;
        end else begin
            num_o <= (sum_pn_q >= {1'b0, prod_old_d2}) ? (sum_pn_q - {1'b0, prod_old_d2}) : '0;
            if (wsum_b_q[WT_W+1])
                wt_o <= '0;
            else if (wsum_b_q[WT_W])
                wt_o <= '1;
            else
                wt_o <= wsum_b_q[WT_W-1:0];
        end
    end

endmodule

// File: rtl/wmean_recip.sv
// Stage 4: normalise the weight and fetch its reciprocal
module wmean_recip #(
    parameter int unsigned WT_W    = 12,
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned FRAC    = 16,
    parameter int unsigned SH_W    = 3,
    localparam int unsigned RECIP_W = FRAC + 1,
    localparam int unsigned MAX_SH  = WT_W - IDX_W,
    localparam int unsigned TBL_N   = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WT_W-1:0]    wt_i,
    output logic [RECIP_W-1:0] recip_o,
    output logic [SH_W-1:0]    sh_o
);

    logic [RECIP_W-1:0] tbl [TBL_N];
    logic [SH_W-1:0]    sh_d;
    logic [IDX_W-1:0]   idx_d;

    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        localparam int unsigned ENT = wmean_pkg::recip_entry(g, FRAC);
        assign tbl[g] = RECIP_W'(ENT);
    end

    // highest set bit above the index field picks the shift
    always_comb begin
        sh_d = '0;
        for (int i = 1; i <= int'(MAX_SH); i++) begin
            if (wt_i[IDX_W+i-1]) sh_d = SH_W'(i);
        end
        idx_d = IDX_W'(wt_i >> sh_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            recip_o <= '0;
            sh_o    <= '0;
        end else begin
            recip_o <= tbl[idx_d];
            sh_o    <= sh_d;
        end
    end

endmodule

// File: rtl/wmean_scale.sv
// Stages 4..6: align numerator, multiply by reciprocal, round, shift, saturate
module wmean_scale #(
    parameter int unsigned PIX_W   = 8,
    parameter int unsigned WT_W    = 12,
    parameter int unsigned NUM_W   = 21,
    parameter int unsigned FRAC    = 16,
    parameter int unsigned SH_W    = 3,
    localparam int unsigned RECIP_W = FRAC + 1,
    localparam int unsigned MUL_W   = NUM_W + RECIP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_W-1:0]   num_i,
    input  logic [WT_W-1:0]    wt_i,
    input  logic [RECIP_W-1:0] recip_i,
    input  logic [SH_W-1:0]    sh_i,
    output logic [PIX_W-1:0]   pix_o,
    output logic [WT_W-1:0]    wt_o
);

    logic [NUM_W-1:0] num_q;
    logic [WT_W-1:0]  wt4_q, wt5_q;
    logic [MUL_W-1:0] prod_q;
    logic [SH_W-1:0]  sh_q;
    logic [MUL_W:0]   rnd_d, quo_d;
    logic [PIX_W-1:0] pix_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_q  <= '0;
            wt4_q  <= '0;
            prod_q <= '0;
            sh_q   <= '0;
            wt5_q  <= '0;
            pix_o  <= '0;
            wt_o   <= '0;
        end else begin
            num_q  <= num_i;
            wt4_q  <= wt_i;
            prod_q <= MUL_W'(num_q) * MUL_W'(recip_i);
            sh_q   <= sh_i;
            wt5_q  <= wt4_q;
            pix_o  <= pix_d;
            wt_o   <= wt5_q;
        end
    end

    always_comb begin
        rnd_d = {1'b0, prod_q} + ((MUL_W+1)'(1) << (FRAC - 1 + int'(sh_q)));
        quo_d = rnd_d >> (FRAC + int'(sh_q));
        pix_d = (|quo_d[MUL_W:PIX_W]) ? '1 : quo_d[PIX_W-1:0];
    end

endmodule

// File: rtl/wmean_slide_upd.sv
module wmean_slide_upd #(
    parameter int unsigned PIX_W   = 8,
    parameter int unsigned WT_W    = 12,
    parameter int unsigned COORD_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] in_coord,
    input  logic [PIX_W-1:0]   prev_pix,
    input  logic [WT_W-1:0]    prev_wt,
    input  logic [PIX_W-1:0]   new_pix,
    input  logic [WT_W-1:0]    new_wt,
    input  logic [PIX_W-1:0]   old_pix,
    input  logic [WT_W-1:0]    old_wt,
    output logic               out_valid,
    output logic [COORD_W-1:0] out_coord,
    output logic [PIX_W-1:0]   out_pix,
    output logic [WT_W-1:0]    out_wt,
    output logic               wb_en,
    output logic [COORD_W-1:0] wb_coord,
    output logic [PIX_W-1:0]   wb_pix,
    output logic [WT_W-1:0]    wb_wt
);

    localparam int unsigned LAT     = wmean_pkg::WM_LAT;
    localparam int unsigned FRAC    = wmean_pkg::WM_RECIP_FRAC;
    localparam int unsigned NUM_W   = PIX_W + WT_W + 1;
    localparam int unsigned RECIP_W = FRAC + 1;
    localparam int unsigned SH_W    = $clog2(WT_W - PIX_W + 2);

    logic [NUM_W-1:0]   num3;
    logic [WT_W-1:0]    wt3;
    logic [RECIP_W-1:0] recip4;
    logic [SH_W-1:0]    sh4;

    wmean_mac #(.PIX_W(PIX_W), .WT_W(WT_W)) i_mac (
        .clk(clk), .rst_n(rst_n),
        .prev_pix(prev_pix), .prev_wt(prev_wt),
        .new_pix(new_pix), .new_wt(new_wt),
        .old_pix(old_pix), .old_wt(old_wt),
        .num_o(num3), .wt_o(wt3)
    );

    wmean_recip #(.WT_W(WT_W), .IDX_W(PIX_W), .FRAC(FRAC), .SH_W(SH_W)) i_recip (
        .clk(clk), .rst_n(rst_n),
        .wt_i(wt3), .recip_o(recip4), .sh_o(sh4)
    );

    wmean_scale #(.PIX_W(PIX_W), .WT_W(WT_W), .NUM_W(NUM_W), .FRAC(FRAC), .SH_W(SH_W)) i_scale (
        .clk(clk), .rst_n(rst_n),
        .num_i(num3), .wt_i(wt3), .recip_i(recip4), .sh_i(sh4),
        .pix_o(out_pix), .wt_o(out_wt)
    );

    // sideband delay line matched to the arithmetic stages
    logic [LAT-1:0]     vld_sr;
    logic [COORD_W-1:0] crd_sr [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_side
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_sr[0] <= 1'b0;
                    crd_sr[0] <= '0;
                end else begin
                    vld_sr[0] <= in_valid;
                    crd_sr[0] <= in_coord;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_sr[g] <= 1'b0;
                    crd_sr[g] <= '0;
                end else begin
                    vld_sr[g] <= vld_sr[g-1];
                    crd_sr[g] <= crd_sr[g-1];
                end
            end
        end
    end

    assign out_valid = vld_sr[LAT-1];
    assign out_coord = crd_sr[LAT-1];

    assign wb_en    = out_valid;
    assign wb_coord = out_coord;
    assign wb_pix   = out_pix;
    assign wb_wt    = out_wt;

endmodule

// File: rtl/wmean_slide_upd_chk.sv
module wmean_slide_upd_chk #(
    parameter int unsigned PIX_W   = 8,
    parameter int unsigned WT_W    = 12,
    parameter int unsigned COORD_W = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [COORD_W-1:0] in_coord,
    input logic [PIX_W-1:0]   prev_pix,
    input logic [WT_W-1:0]    prev_wt,
    input logic [PIX_W-1:0]   new_pix,
    input logic [WT_W-1:0]    new_wt,
    input logic [PIX_W-1:0]   old_pix,
    input logic [WT_W-1:0]    old_wt,
    input logic               out_valid,
    input logic [COORD_W-1:0] out_coord,
    input logic [PIX_W-1:0]   out_pix,
    input logic [WT_W-1:0]    out_wt,
    input logic               wb_en,
    input logic [COORD_W-1:0] wb_coord,
    input logic [PIX_W-1:0]   wb_pix,
    input logic [WT_W-1:0]    wb_wt
);

    localparam int unsigned LAT = wmean_pkg::WM_LAT;

    int unsigned            since_rst;
    logic signed [WT_W+1:0] wraw;
    logic [WT_W-1:0]        wclip;
    logic [WT_W-1:0]        wexp_sr [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= 0;
        else if (since_rst < LAT) since_rst <= since_rst + 1;
    end

    always_comb begin
        wraw = $signed({2'b00, prev_wt}) + $signed({2'b00, new_wt}) - $signed({2'b00, old_wt});
        if (wraw <= 0) wclip = '0;
        else if (wraw > $signed({2'b00, {WT_W{1'b1}}})) wclip = '1;
        else wclip = wraw[WT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(LAT); i++) wexp_sr[i] <= '0;
        end else begin
            wexp_sr[0] <= wclip;
            for (int i = 1; i < int'(LAT); i++) wexp_sr[i] <= wexp_sr[i-1];
        end
    end

    AST_WT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == LAT && out_valid) |-> out_wt == wexp_sr[LAT-1]); // R1

    AST_MISSING_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_wt == '0) |-> out_pix == '0); // R5

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == LAT) |-> out_valid == $past(in_valid, 6)); // R6

    AST_COORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == LAT && out_valid) |-> out_coord == $past(in_coord, 6)); // R8

endmodule

bind wmean_slide_upd wmean_slide_upd_chk #(.PIX_W(PIX_W), .WT_W(WT_W), .COORD_W(COORD_W)) i_chk (.*);

// File: tb/test_wmean_slide_upd.sv
`timescale 1ns/1ps
module test_wmean_slide_upd;

    localparam int PIX_W = 8;
    localparam int WT_W = 12;
    localparam int COORD_W = 22;
    localparam int LAT = 6;
    localparam int QN = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [COORD_W-1:0] in_coord = '0;
    logic [PIX_W-1:0] prev_pix = '0, new_pix = '0, old_pix = '0;
    logic [WT_W-1:0] prev_wt = '0, new_wt = '0, old_wt = '0;
    logic out_valid, wb_en;
    logic [COORD_W-1:0] out_coord, wb_coord;
    logic [PIX_W-1:0] out_pix, wb_pix;
    logic [WT_W-1:0] out_wt, wb_wt;

    always #10 clk = ~clk;

    wmean_slide_upd #(.PIX_W(PIX_W), .WT_W(WT_W), .COORD_W(COORD_W)) i_wmean_slide_upd (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coord(in_coord),
        .prev_pix(prev_pix), .prev_wt(prev_wt), .new_pix(new_pix), .new_wt(new_wt),
        .old_pix(old_pix), .old_wt(old_wt),
        .out_valid(out_valid), .out_coord(out_coord), .out_pix(out_pix), .out_wt(out_wt),
        .wb_en(wb_en), .wb_coord(wb_coord), .wb_pix(wb_pix), .wb_wt(wb_wt)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int q_head = 0;
    int q_tail = 0;
    int run_len = 0;
    int max_run = 0;
    int exp_pix_q [QN];
    int exp_wt_q [QN];
    int exp_crd_q [QN];
    int exp_cyc_q [QN];
    int unsigned lcg = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int model_wt(int pw, int nw, int ow);
        int s = pw + nw - ow;
        if (s <= 0) return 0;
        if (s > 4095) return 4095;
        return s;
    endfunction

    function automatic int model_pix(int pp, int pw, int np, int nw, int op, int ow);
        int w = model_wt(pw, nw, ow);
        longint n, t, r;
        int m, s;
        if (w == 0) return 0;
        n = longint'(pp) * pw + longint'(np) * nw - longint'(op) * ow;
        if (n < 0) n = 0;
        m = w; s = 0;
        while (m > 255) begin m = m >> 1; s++; end
        t = (65536 + m / 2) / m;
        r = (n * t + (longint'(1) << (15 + s))) >>> (16 + s);
        if (r > 255) r = 255;
        return int'(r);
    endfunction

    task automatic check(string req, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor: results in order, with latency, coordinate and write-back mirror
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                run_len++;
                if (run_len > max_run) max_run = run_len;
                if (q_head == q_tail) begin
                    check("R6", 1, 0, "unexpected out_valid");
                end else begin
                    check("R6", cyc - exp_cyc_q[q_head % QN], LAT, "latency");
                    check("R8", int'(out_coord), exp_crd_q[q_head % QN], "coord");
                    check("R1", int'(out_wt), exp_wt_q[q_head % QN], "weight");
                    check("R3", int'(out_pix), exp_pix_q[q_head % QN], "intensity");
                    q_head++;
                end
            end else begin
                run_len = 0;
            end
            check("R9", int'({wb_en, wb_coord, wb_pix, wb_wt}),
                  int'({out_valid, out_coord, out_pix, out_wt}), "write-back mirror");
        end
    end

    task automatic push(int crd, int pp, int pw, int np, int nw, int op, int ow);
        @(negedge clk);
        in_valid = 1'b1;
        in_coord = COORD_W'(crd);
        prev_pix = PIX_W'(pp); prev_wt = WT_W'(pw);
        new_pix = PIX_W'(np); new_wt = WT_W'(nw);
        old_pix = PIX_W'(op); old_wt = WT_W'(ow);
        exp_pix_q[q_tail % QN] = model_pix(pp, pw, np, nw, op, ow);
        exp_wt_q[q_tail % QN] = model_wt(pw, nw, ow);
        exp_crd_q[q_tail % QN] = crd;
        exp_cyc_q[q_tail % QN] = cyc;
        q_tail++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic drain(string req);
        idle(LAT + 2);
        check(req, q_tail - q_head, 0, "results outstanding");
    endtask

    task automatic t_reset();
        repeat (3) begin
            @(negedge clk);
            check("R6", int'(out_valid), 0, "out_valid in reset");
            check("R9", int'(wb_en), 0, "wb_en in reset");
        end
        rst_n = 1'b1;
        idle(LAT + 1);
        check("R6", int'(out_valid), 0, "out_valid idle after reset");
    endtask

    task automatic t_exact();   // R2 R3: small weights, exact means
        push(1, 0, 0, 100, 10, 0, 0);
        push(2, 100, 10, 50, 10, 0, 0);
        push(3, 80, 20, 200, 20, 80, 20);
        push(4, 7, 1, 0, 0, 0, 0);
        push(5, 200, 255, 0, 0, 0, 0);
        drain("R2");
    endtask

    task automatic t_shifted(); // R3 R1: weights crossing normalisation boundaries
        push(10, 100, 255, 100, 1, 0, 0);
        push(11, 200, 3000, 50, 500, 120, 400);
        push(12, 255, 2048, 1, 2047, 0, 0);
        push(13, 33, 511, 99, 1, 0, 0);
        push(14, 128, 1024, 64, 1023, 10, 5);
        drain("R3");
    endtask

    task automatic t_missing(); // R5 R1: weight exactly zero and negative
        push(20, 90, 10, 40, 5, 200, 15);
        push(21, 90, 10, 40, 5, 200, 40);
        push(22, 0, 0, 0, 0, 0, 0);
        drain("R5");
    endtask

    task automatic t_negnum();  // R2: numerator below zero under positive weight
        push(30, 0, 5, 0, 5, 200, 5);
        push(31, 10, 50, 0, 0, 255, 40);
        drain("R2");
    endtask

    task automatic t_saturate(); // R4: quotient above 255
        push(40, 255, 10, 255, 10, 0, 10);
        push(41, 255, 4000, 255, 4000, 0, 3000);
        drain("R4");
    endtask

    task automatic t_clip();    // R1: sum above 4095
        push(50, 100, 4000, 100, 4000, 100, 100);
        push(51, 20, 4095, 30, 1, 0, 0);
        drain("R1");
    endtask

    task automatic t_stream();  // R7: 40 back-to-back inputs give 40 back-to-back outputs
        max_run = 0;
        for (int i = 0; i < 40; i++) begin
            int v [6];
            for (int k = 0; k < 6; k++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                v[k] = int'(lcg >> 16);
            end
            push(100 + i, v[0] & 255, v[1] & 4095, v[2] & 255, v[3] & 1023,
                 v[4] & 255, v[5] & 511);
        end
        drain("R7");
        check("R7", max_run, 40, "consecutive output run");
    endtask

    task automatic t_bubble();  // R7 R8: gaps preserved
        max_run = 0;
        for (int i = 0; i < 6; i++) begin
            push(300 + i, 10 * i, 3, 40, 2, 0, 0);
            idle(1);
        end
        drain("R7");
        check("R7", max_run, 1, "gaps preserved");
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_exact();
        t_shifted();
        t_missing();
        t_negnum();
        t_saturate();
        t_clip();
        t_stream();
        t_bubble();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule